// File: doc/BRIEF.md
# Fully Associative Address Translation Buffer

This block caches virtual-to-physical page translations for a 32-bit effective address space. Every entry carries its own page size (4 kB, 16 kB, 512 kB or 8 MB), so the tag compare for each entry covers only the virtual page bits above that entry's offset. A lookup is compared against all entries in parallel. One clock later the block reports one of three outcomes: a hit with the physical address and the entry's protection bits, a miss, or a protection fault.

A miss does not start any hardware table walk. It is reported so that system software can trap, fetch the translation itself, and load it through the refill port. A round-robin pointer chooses which entry each refill overwrites. A single invalidate-all input empties the whole buffer.

The block keeps no state shared between instances. One instance serves instruction fetches and a second, identical instance serves data accesses.

Top module: `tlb_fa`

## Requirements
- R1: After reset every entry is invalid and all result outputs are 0. The first lookup after reset therefore misses.
- R2: The result of a lookup presented in cycle t appears in cycle t+1 with rs_valid high. Exactly one of rs_hit, rs_miss and rs_fault is high whenever rs_valid is high, and all three are low when rs_valid is low.
- R3: On a hit through a 4 kB entry, rs_paddr equals the entry's 20-bit physical page number followed by vaddr[11:0].
- R4: The page size field uses these codes: 2'b00 = 4 kB, 2'b01 = 16 kB, 2'b10 = 512 kB, 2'b11 = 8 MB, giving 12, 14, 19 or 23 offset bits. Two rules follow from the offset width:
  - Stored virtual page bits below the offset are ignored in the compare.
  - On a hit, the offset bits of rs_paddr come from vaddr and the upper bits come from the stored physical page.
- R5: A lookup that matches no valid entry reports rs_miss, and rs_paddr, rs_ro and rs_sup are all 0.
- R6: A matching access raises rs_fault instead of rs_hit in two cases: a write (lk_write=1) to an entry with ro=1, or a user access (lk_user=1) to an entry with sup=1. On a fault rs_paddr is 0. On both hit and fault, rs_ro and rs_sup report the matched entry's bits.
- R7: Each accepted refill writes the entry selected by a replacement pointer. The pointer starts at entry 0 and advances by one per refill, wrapping after the last entry. The 33rd refill after reset therefore overwrites the first.
- R8: Asserting inv_all clears every valid bit in one cycle and returns the replacement pointer to entry 0. A refill presented in the same cycle is discarded.
- R9: A lookup presented in the same cycle as a refill sees the buffer contents from before that refill.
- R10: When several valid entries match, the lowest-index entry supplies the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| lk_valid | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_write | input | 1 | Access is a write |
| lk_user | input | 1 | Access is from user mode |
| rf_valid | input | 1 | Refill request |
| rf_vpage | input | 20 | Virtual page number (vaddr[31:12]) of the new entry |
| rf_ppage | input | 20 | Physical page number of the new entry |
| rf_size | input | 2 | Page size code of the new entry |
| rf_ro | input | 1 | New entry is read-only |
| rf_sup | input | 1 | New entry is supervisor-only |
| inv_all | input | 1 | Invalidate every entry |
| rs_valid | output | 1 | Lookup result present |
| rs_hit | output | 1 | Translation succeeded |
| rs_miss | output | 1 | No entry matched; software trap |
| rs_fault | output | 1 | Protection violation |
| rs_paddr | output | 32 | Translated physical address |
| rs_ro | output | 1 | Matched entry's read-only bit |
| rs_sup | output | 1 | Matched entry's supervisor bit |

## Verification
The replacement pointer is the hardest state to reach from the ports, because it can only be seen when a refill overwrites an entry that a later lookup expects to find. The bench therefore loads the buffer until it wraps and confirms that the oldest translation disappears while the next one survives. It then repeats the full wrap after an invalidate-all to show that the pointer restarted at entry 0. Other cases are built on purpose:
- Duplicate tags, to check that the lowest-index entry wins.
- A lookup issued in the same cycle as a refill, to check that it sees the old contents.
- Large pages stored with junk low tag bits, to check that those bits are ignored.

// File: rtl/tlb_fa_pkg.sv
package tlb_fa_pkg;

   localparam int unsigned PG_SHIFT = 12;

   typedef enum logic [1:0] {
      PG_4K   = 2'b00,
      PG_16K  = 2'b01,
      PG_512K = 2'b10,
      PG_8M   = 2'b11
   } pg_size_e;

   // Number of page-number bits that become offset bits for a size code.
   function automatic int unsigned pg_extra(input pg_size_e s);
      case (s)
         PG_4K:   return 0;
         PG_16K:  return 2;
         PG_512K: return 7;
         default: return 11;
      endcase
   endfunction

endpackage

// File: rtl/tlb_fa_entry.sv
module tlb_fa_entry
   import tlb_fa_pkg::*;
#(
   parameter int unsigned VPN_W = 20
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic             inv,
   input  logic [VPN_W-1:0] wr_vpn,
   input  logic [VPN_W-1:0] wr_ppn,
   input  logic [1:0]       wr_size,
   input  logic             wr_ro,
   input  logic             wr_sup,
   input  logic [VPN_W-1:0] cmp_vpn,
   output logic             match,
   output logic [VPN_W-1:0] ppn_o,
   output logic [VPN_W-1:0] keep_o,
   output logic             ro_o,
   output logic             sup_o
);

   logic             valid_q;
   logic [VPN_W-1:0] vpn_q;
   logic [VPN_W-1:0] ppn_q;
   pg_size_e         size_q;
   logic             ro_q;
   logic             sup_q;

   always_ff @(posedge clk) begin
      if (!rst_n || inv) begin
         valid_q <= 1'b0;
      end else if (wr_en) begin
         valid_q <= 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr_en && !inv) begin
         vpn_q  <= wr_vpn;
         ppn_q  <= wr_ppn;
         size_q <= pg_size_e'(wr_size);
         ro_q   <= wr_ro;
         sup_q  <= wr_sup;
      end
   end

   // Keep mask: a 1 marks a page-number bit that takes part in translation.
   always_comb begin
      int unsigned extra;
      extra = pg_extra(size_q);
      for (int unsigned i = 0; i < VPN_W; i++) begin
         keep_o[i] = (i >= extra);
      end
   end

   assign match = valid_q && (((vpn_q ^ cmp_vpn) & keep_o) == '0);
   assign ppn_o = ppn_q & keep_o;
   assign ro_o  = ro_q;
   assign sup_o = sup_q;

endmodule

// File: rtl/tlb_fa_repl.sv
module tlb_fa_repl #(
   parameter int unsigned N_ENTRIES = 32,
   localparam int unsigned PTR_W    = $clog2(N_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             adv,
   input  logic             clr,
   output logic [PTR_W-1:0] ptr
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(N_ENTRIES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n || clr) begin
         ptr <= '0;
      end else if (adv) begin
         ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
      end
   end

endmodule

// File: rtl/tlb_fa_prot.sv
module tlb_fa_prot (
   input  logic is_write,
   input  logic is_user,
   input  logic pg_ro,
   input  logic pg_sup,
   output logic fault
);

   assign fault = (is_write && pg_ro) || (is_user && pg_sup);

endmodule

// File: rtl/tlb_fa.sv
module tlb_fa
   import tlb_fa_pkg::*;
#(
   parameter int unsigned N_ENTRIES = 32,
   parameter int unsigned VA_W      = 32,
   localparam int unsigned VPN_W    = VA_W - PG_SHIFT,
   localparam int unsigned PTR_W    = $clog2(N_ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             lk_valid,
   input  logic [VA_W-1:0]  lk_vaddr,
   input  logic             lk_write,
   input  logic             lk_user,
   input  logic             rf_valid,
   input  logic [VPN_W-1:0] rf_vpage,
   input  logic [VPN_W-1:0] rf_ppage,
   input  logic [1:0]       rf_size,
   input  logic             rf_ro,
   input  logic             rf_sup,
   input  logic             inv_all,
   output logic             rs_valid,
   output logic             rs_hit,
   output logic             rs_miss,
   output logic             rs_fault,
   output logic [VA_W-1:0]  rs_paddr,
   output logic             rs_ro,
   output logic             rs_sup
);

   if (N_ENTRIES < 2 || N_ENTRIES > 256) begin : g_bad_depth
      $error("tlb_fa: N_ENTRIES must be 2..256");
   end
   if (VA_W < 24 || VA_W > 64) begin : g_bad_width
      $error("tlb_fa: VA_W must be 24..64");
   end

   logic [PTR_W-1:0] repl_ptr;
   logic             do_refill;
   logic [VPN_W-1:0] cmp_vpn;

   logic [N_ENTRIES-1:0] e_match;
   logic [N_ENTRIES-1:0] e_ro;
   logic [N_ENTRIES-1:0] e_sup;
   logic [VPN_W-1:0]     e_ppn  [N_ENTRIES];
   logic [VPN_W-1:0]     e_keep [N_ENTRIES];

   assign do_refill = rf_valid && !inv_all;
   assign cmp_vpn   = lk_vaddr[VA_W-1:PG_SHIFT];

   tlb_fa_repl #(.N_ENTRIES(N_ENTRIES)) u_repl (
      .clk   (clk),
      .rst_n (rst_n),
      .adv   (do_refill),
      .clr   (inv_all),
      .ptr   (repl_ptr)
   );

   for (genvar i = 0; i < N_ENTRIES; i++) begin : g_ent
      tlb_fa_entry #(.VPN_W(VPN_W)) u_ent (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (do_refill && (repl_ptr == PTR_W'(i))),
         .inv     (inv_all),
         .wr_vpn  (rf_vpage),
         .wr_ppn  (rf_ppage),
         .wr_size (rf_size),
         .wr_ro   (rf_ro),
         .wr_sup  (rf_sup),
         .cmp_vpn (cmp_vpn),
         .match   (e_match[i]),
         .ppn_o   (e_ppn[i]),
         .keep_o  (e_keep[i]),
         .ro_o    (e_ro[i]),
         .sup_o   (e_sup[i])
      );
   end

   // Lowest-index matching entry wins.
   logic             any_match;
   logic [VPN_W-1:0] sel_ppn;
   logic [VPN_W-1:0] sel_keep;
   logic             sel_ro;
   logic             sel_sup;

   always_comb begin
      sel_ppn  = '0;
      sel_keep = '0;
      sel_ro   = 1'b0;
      sel_sup  = 1'b0;
      for (int i = N_ENTRIES - 1; i >= 0; i--) begin
         if (e_match[i]) begin
            sel_ppn  = e_ppn[i];
            sel_keep = e_keep[i];
            sel_ro   = e_ro[i];
            sel_sup  = e_sup[i];
         end
      end
   end

   assign any_match = |e_match;

   logic prot_fault;

   tlb_fa_prot u_prot (
      .is_write (lk_write),
      .is_user  (lk_user),
      .pg_ro    (sel_ro),
      .pg_sup   (sel_sup),
      .fault    (prot_fault)
   );

   logic [VA_W-1:0] paddr_c;
   assign paddr_c = {sel_ppn, PG_SHIFT'(0)}
                  | (lk_vaddr & {~sel_keep, {PG_SHIFT{1'b1}}});

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rs_valid <= 1'b0;
         rs_hit   <= 1'b0;
         rs_miss  <= 1'b0;
         rs_fault <= 1'b0;
         rs_paddr <= '0;
         rs_ro    <= 1'b0;
         rs_sup   <= 1'b0;
      end else begin
         rs_valid <= lk_valid;
         rs_hit   <= lk_valid && any_match && !prot_fault;
         rs_miss  <= lk_valid && !any_match;
         rs_fault <= lk_valid && any_match && prot_fault;
         rs_paddr <= (lk_valid && any_match && !prot_fault) ? paddr_c : '0;
         rs_ro    <= lk_valid && any_match && sel_ro;
         rs_sup   <= lk_valid && any_match && sel_sup;
      end
   end

endmodule

// File: rtl/tlb_fa_chk.sv
module tlb_fa_chk #(
   parameter int unsigned N_ENTRIES = 32,
   localparam int unsigned PTR_W    = $clog2(N_ENTRIES)
) (
   input logic             clk,
   input logic             rst_n,
   input logic             lk_valid,
   input logic             lk_write,
   input logic             lk_user,
   input logic             rf_valid,
   input logic             inv_all,
   input logic             rs_valid,
   input logic             rs_hit,
   input logic             rs_miss,
   input logic             rs_fault,
   input logic             rs_ro,
   input logic             rs_sup,
   input logic [PTR_W-1:0] repl_ptr
);

   localparam logic [PTR_W-1:0] LAST = PTR_W'(N_ENTRIES - 1);

   // R2: result follows a request by exactly one cycle
   a_r2_latency: assert property (@(posedge clk) disable iff (!rst_n)
      lk_valid |=> rs_valid);
   a_r2_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
      !lk_valid |=> !rs_valid);
   // R2: one outcome per result, none without a result
   a_r2_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
      rs_valid |-> ($countones({rs_hit, rs_miss, rs_fault}) == 1));
   a_r2_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rs_valid |-> !(rs_hit || rs_miss || rs_fault));
   // R6: no hit for a write to a read-only page or a user access to a supervisor page
   a_r6_write_ro: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_write) |=> !(rs_hit && rs_ro));
   a_r6_user_sup: assert property (@(posedge clk) disable iff (!rst_n)
      (lk_valid && lk_user) |=> !(rs_hit && rs_sup));
   // R7: pointer advances by one per accepted refill and wraps
   a_r7_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (rf_valid && !inv_all) |=>
         (repl_ptr == (($past(repl_ptr) == LAST) ? '0 : $past(repl_ptr) + 1'b1)));
   a_r7_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (!rf_valid && !inv_all) |=> $stable(repl_ptr));
   // R8: invalidate returns the pointer to zero and empties the buffer
   a_r8_ptr_clear: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (repl_ptr == '0));
   a_r8_empty: assert property (@(posedge clk) disable iff (!rst_n)
      inv_all |=> (lk_valid |=> rs_miss));

endmodule

bind tlb_fa tlb_fa_chk #(.N_ENTRIES(N_ENTRIES)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .lk_valid (lk_valid),
   .lk_write (lk_write),
   .lk_user  (lk_user),
   .rf_valid (rf_valid),
   .inv_all  (inv_all),
   .rs_valid (rs_valid),
   .rs_hit   (rs_hit),
   .rs_miss  (rs_miss),
   .rs_fault (rs_fault),
   .rs_ro    (rs_ro),
   .rs_sup   (rs_sup),
   .repl_ptr (repl_ptr)
);

// File: tb/tb_tlb_fa.sv
`timescale 1ns/1ps
module tb_tlb_fa;

   logic        clk = 1'b0;
   logic        rst_n;
   logic        lk_valid, lk_write, lk_user;
   logic [31:0] lk_vaddr;
   logic        rf_valid, rf_ro, rf_sup, inv_all;
   logic [19:0] rf_vpage, rf_ppage;
   logic [1:0]  rf_size;
   logic        rs_valid, rs_hit, rs_miss, rs_fault, rs_ro, rs_sup;
   logic [31:0] rs_paddr;

   always #4 clk = ~clk;

   tlb_fa dut (
      .clk(clk), .rst_n(rst_n),
      .lk_valid(lk_valid), .lk_vaddr(lk_vaddr), .lk_write(lk_write), .lk_user(lk_user),
      .rf_valid(rf_valid), .rf_vpage(rf_vpage), .rf_ppage(rf_ppage), .rf_size(rf_size),
      .rf_ro(rf_ro), .rf_sup(rf_sup), .inv_all(inv_all),
      .rs_valid(rs_valid), .rs_hit(rs_hit), .rs_miss(rs_miss), .rs_fault(rs_fault),
      .rs_paddr(rs_paddr), .rs_ro(rs_ro), .rs_sup(rs_sup)
   );

   typedef struct {
      logic        hit, miss, fault, ro, sup;
      logic [31:0] pa;
      string       tag;
   } exp_t;

   exp_t sb[$];
   int   n_chk = 0;
   int   n_bad = 0;

   // Monitor: pop and compare each result half a cycle after it appears.
   always @(negedge clk) begin
      if (rst_n && rs_valid) begin
         if (sb.size() == 0) begin
            n_chk++; n_bad++;
            $display("FAIL R2 unexpected result: got rs_valid=1 expected 0");
         end else begin
            exp_t e;
            e = sb.pop_front();
            n_chk++;
            if ({rs_hit, rs_miss, rs_fault, rs_ro, rs_sup} !== {e.hit, e.miss, e.fault, e.ro, e.sup}
                || rs_paddr !== e.pa) begin
               n_bad++;
               $display("FAIL %s: got h/m/f/ro/sup=%b%b%b%b%b pa=%h expected %b%b%b%b%b pa=%h",
                        e.tag, rs_hit, rs_miss, rs_fault, rs_ro, rs_sup, rs_paddr,
                        e.hit, e.miss, e.fault, e.ro, e.sup, e.pa);
            end
         end
      end
   end

   task automatic tick();
      @(posedge clk); #1;
   endtask

   task automatic refill(input logic [19:0] vp, input logic [19:0] pp, input logic [1:0] sz,
                         input logic ro, input logic sup);
      rf_valid = 1'b1; rf_vpage = vp; rf_ppage = pp; rf_size = sz; rf_ro = ro; rf_sup = sup;
      tick();
      rf_valid = 1'b0;
   endtask

   task automatic look(input logic [31:0] va, input logic w, input logic u,
                       input logic h, input logic m, input logic f, input logic [31:0] pa,
                       input logic ro, input logic sup, input string tag);
      exp_t e;
      e.hit = h; e.miss = m; e.fault = f; e.pa = pa; e.ro = ro; e.sup = sup; e.tag = tag;
      sb.push_back(e);
      lk_valid = 1'b1; lk_vaddr = va; lk_write = w; lk_user = u;
      tick();
      lk_valid = 1'b0;
   endtask

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

   initial begin
      rst_n = 1'b0; lk_valid = 0; lk_write = 0; lk_user = 0; lk_vaddr = '0;
      rf_valid = 0; rf_vpage = '0; rf_ppage = '0; rf_size = 0; rf_ro = 0; rf_sup = 0;
      inv_all = 0;
      repeat (3) tick();
      rst_n = 1'b1;
      @(negedge clk);
      n_chk++;
      if ({rs_valid, rs_hit, rs_miss, rs_fault, rs_ro, rs_sup} !== 6'b0 || rs_paddr !== '0) begin
         n_bad++;
         $display("FAIL R1 reset outputs: got %b pa=%h expected 000000 pa=0",
                  {rs_valid, rs_hit, rs_miss, rs_fault, rs_ro, rs_sup}, rs_paddr);
      end
      tick();
      look(32'h1234_5678, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R1 empty after reset");

      // entries 0..5
      refill(20'h12345, 20'hABCDE, 2'b00, 0, 0);
      refill(20'h40000, 20'h00123, 2'b01, 0, 0);
      refill(20'h80071, 20'h12345, 2'b10, 0, 0);
      refill(20'hC0000, 20'h00800, 2'b11, 0, 0);
      refill(20'h00010, 20'h00020, 2'b00, 1, 0);
      refill(20'h00011, 20'h00021, 2'b00, 0, 1);
      look(32'h1234_5678, 0, 1, 1, 0, 0, 32'hABCD_E678, 0, 0, "R3 4k hit");
      look(32'h1234_6678, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R5 neighbour page miss");
      look(32'h4000_3ABC, 1, 0, 1, 0, 0, 32'h0012_3ABC, 0, 0, "R4 16k hit");
      look(32'h4000_4000, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R4 16k outside miss");
      look(32'h8007_FFFF, 0, 0, 1, 0, 0, 32'h1237_FFFF, 0, 0, "R4 512k hit ignoring low tag");
      look(32'hC07F_FFF0, 0, 0, 1, 0, 0, 32'h00FF_FFF0, 0, 0, "R4 8M hit");
      look(32'hC080_0000, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R4 8M outside miss");
      look(32'h0001_0004, 0, 1, 1, 0, 0, 32'h0002_0004, 1, 0, "R6 read of ro page");
      look(32'h0001_0004, 1, 0, 0, 0, 1, 32'h0, 1, 0, "R6 write to ro page");
      look(32'h0001_1008, 0, 1, 0, 0, 1, 32'h0, 0, 1, "R6 user to sup page");
      look(32'h0001_1008, 1, 0, 1, 0, 0, 32'h0002_1008, 0, 1, "R6 supervisor on sup page");

      // entry 6: duplicate tag, entry 0 must still win
      refill(20'h12345, 20'h55555, 2'b00, 0, 0);
      look(32'h1234_5000, 0, 0, 1, 0, 0, 32'hABCD_E000, 0, 0, "R10 lowest index wins");

      // entry 7 written in the same cycle as a lookup of it
      rf_valid = 1'b1; rf_vpage = 20'h00777; rf_ppage = 20'h00999; rf_size = 0; rf_ro = 0; rf_sup = 0;
      look(32'h0077_7000, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R9 same-cycle refill unseen");
      rf_valid = 1'b0;
      look(32'h0077_7000, 0, 0, 1, 0, 0, 32'h0099_9000, 0, 0, "R9 refill visible next");

      // entries 8..31, then wrap onto entry 0
      for (int i = 0; i < 24; i++) refill(20'h01000 + 20'(i), 20'h02000 + 20'(i), 2'b00, 0, 0);
      refill(20'h03333, 20'h04444, 2'b00, 0, 0);
      look(32'h1234_5678, 0, 0, 1, 0, 0, 32'h5555_5678, 0, 0, "R7 wrap replaced entry 0");
      look(32'h0333_3001, 0, 0, 1, 0, 0, 32'h0444_4001, 0, 0, "R7 new entry hit");
      look(32'h4000_3ABC, 0, 0, 1, 0, 0, 32'h0012_3ABC, 0, 0, "R7 entry 1 kept");
      look(32'h0101_7000, 0, 0, 1, 0, 0, 32'h0201_7000, 0, 0, "R7 entry 31 present");

      // invalidate with a colliding refill
      inv_all = 1'b1; rf_valid = 1'b1; rf_vpage = 20'h06666; rf_ppage = 20'h06666; rf_size = 0;
      tick();
      inv_all = 1'b0; rf_valid = 1'b0;
      look(32'h0333_3000, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R8 invalidate cleared");
      look(32'h0666_6000, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R8 colliding refill dropped");

      // pointer restarted at 0: 32 refills fill 0..31, the 33rd replaces entry 0
      for (int i = 0; i < 32; i++) refill(20'h07000 + 20'(i), 20'h17000 + 20'(i), 2'b00, 0, 0);
      refill(20'h08000, 20'h18000, 2'b00, 0, 0);
      look(32'h0700_0000, 0, 0, 0, 1, 0, 32'h0, 0, 0, "R8 pointer reset, entry 0 replaced");
      look(32'h0700_1000, 0, 0, 1, 0, 0, 32'h1700_1000, 0, 0, "R8 entry 1 kept");
      look(32'h0800_0000, 0, 0, 1, 0, 0, 32'h1800_0000, 0, 0, "R8 new entry hit");

      repeat (4) tick();
      n_chk++;
      if (sb.size() != 0) begin
         n_bad++;
         $display("FAIL R2 results missing: got %0d pending expected 0", sb.size());
      end
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
   end

endmodule